// File: doc/BRIEF.md
# Branch and Stack Control Unit

This unit carries out the control-transfer instructions of a small 8-bit processor that has a 16-bit address space. It owns the program counter and the stack pointer. It runs relative jumps, absolute jumps, jumps through a register pair, calls, returns and restart vectors. Each of these except the register-pair jump and the restart may be made conditional on a flag. Operand bytes and stack traffic go over one byte-wide memory port. Each access is held until the memory acknowledges it.

The decoder raises `start` for one cycle with the operation, the condition select, the restart vector field, the current flag byte and the register-pair value. When `start` arrives, `pc_out` already points at the first operand byte, just past the opcode. The unit then performs its memory transfers. On completion it gives a one-cycle `done` pulse that carries the new program counter and the machine-cycle cost. That cost depends on whether the condition was met.

Top module: `branch_stack_unit`

## Requirements
- R1: After reset, `pc_out` equals `PC_INIT` and `sp_out` equals `SP_INIT`. `busy`, `done` and `mem_req` are all low, and no memory request is made while the unit is idle.
- R2: A 16-bit operand is read as two byte transfers at `pc_out` and `pc_out+1`, low byte first. The program counter moves forward by 2 whether or not the transfer is taken.
- R3: A relative jump reads one offset byte. It treats the byte as signed and adds it to the operand address plus one. When the jump is not taken, the result is the operand address plus one.
- R4: A push first lowers SP by 2, then writes the low byte at the new SP and the high byte at SP+1. Memory writes only ever target SP or SP+1.
- R5: A return reads the low byte at SP and the high byte at SP+1, loads PC with the result, then raises SP by 2. SP only ever changes in steps of 2.
- R6: The condition select picks the test as follows: 0 = Z clear, 1 = Z set, 2 = CY clear, 3 = CY set. Z is flag bit 7 and CY is flag bit 4. With `cond_en` low the transfer is always taken.
- R7: The `op` encoding is 0 relative jump, 1 absolute jump, 2 jump to `hl`, 3 call, 4 return, 5 restart. The unconditional costs are 12, 16, 4, 24, 16 and 16 cycles in that order.
- R8: The conditional costs, given as not taken / taken, are: relative jump 8/12, absolute jump 12/16, call 12/24, return 8/20.
- R9: A restart pushes the current PC and jumps to the 3-bit vector field times 8 (0x00 to 0x38). `cond_en` has no effect on a restart.
- R10: A jump to `hl` completes on the next edge with no memory access, costs 4 cycles, and ignores `cond_en`.
- R11: A `start` that arrives while `busy` is high is ignored. It produces no extra `done` and does not change PC.
- R12: `mem_req`, `mem_addr` and `mem_we` stay stable until `mem_ack`. `done` only comes with the unit idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one transfer operation |
| op | input | 3 | Operation code (see R7) |
| cond_en | input | 1 | Make the operation conditional |
| cond_sel | input | 2 | Condition select (see R6) |
| vec_sel | input | 3 | Restart vector field |
| flags | input | 8 | Current flag byte |
| hl | input | 16 | Register-pair jump target |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | 16 | Transfer address |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | Transfer accepted this cycle |
| mem_rdata | input | 8 | Read byte, valid with `mem_ack` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| done_cycles | output | CYC_W | Machine-cycle cost of the completed operation |
| done_pc | output | 16 | Program counter after the operation |
| pc_out | output | 16 | Current program counter |
| sp_out | output | 16 | Current stack pointer |

## Verification
The bench builds the unit with `PC_INIT` = 0x0100 and `SP_INIT` = 0x0F00. This keeps code, targets and stack inside the bench's 4 KiB memory model. With these values a negative relative offset of −128, nested calls and restart vectors down to 0x00 can all run without aliasing. The memory's acknowledge latency is changed between 0 and 2 wait cycles, which holds requests open across several edges. The default `CYC_W` of 5 makes the largest cost, 24, the widest value the result field must carry.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

  localparam int ADDR_W = 16;

  typedef enum logic [2:0] {
    OP_JR   = 3'd0,
    OP_JP   = 3'd1,
    OP_JPHL = 3'd2,
    OP_CALL = 3'd3,
    OP_RET  = 3'd4,
    OP_RST  = 3'd5
  } xfer_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH_LO,
    ST_FETCH_HI,
    ST_PUSH_LO,
    ST_PUSH_HI,
    ST_POP_LO,
    ST_POP_HI
  } seq_state_e;

  // Signed 8-bit displacement applied to a 16-bit base.
  function automatic logic [ADDR_W-1:0] rel_target(input logic [ADDR_W-1:0] base,
                                                    input logic [7:0] off);
    return base + {{(ADDR_W-8){off[7]}}, off};
  endfunction

  // Restart vector: field scaled by eight.
  function automatic logic [ADDR_W-1:0] rst_target(input logic [2:0] field);
    return {{(ADDR_W-6){1'b0}}, field, 3'b000};
  endfunction

  // Machine-cycle cost; take is forced high when the op is unconditional.
  function automatic logic [7:0] xfer_cost(input xfer_op_e op, input logic cond_en,
                                           input logic take);
    logic [7:0] c;
    case (op)
      OP_JR:   c = take ? 8'd12 : 8'd8;
      OP_JP:   c = take ? 8'd16 : 8'd12;
      OP_JPHL: c = 8'd4;
      OP_CALL: c = take ? 8'd24 : 8'd12;
      OP_RET:  c = !cond_en ? 8'd16 : (take ? 8'd20 : 8'd8);
      OP_RST:  c = 8'd16;
      default: c = 8'd0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/bsu_cond_eval.sv
module bsu_cond_eval #(
  parameter int FLAG_W    = 8,
  parameter int ZERO_BIT  = 7,
  parameter int CARRY_BIT = 4
) (
  input  logic [FLAG_W-1:0] flags,
  input  logic [1:0]        sel,
  input  logic              cond_en,
  output logic              take
);
  logic picked;

  always_comb begin
    picked = sel[1] ? flags[CARRY_BIT] : flags[ZERO_BIT];
    take   = !cond_en || (picked == sel[0]);
  end
endmodule

// File: rtl/bsu_cost_calc.sv
module bsu_cost_calc
  import bsu_pkg::*;
#(
  parameter int CYC_W = 5
) (
  input  xfer_op_e          op,
  input  logic              cond_en,
  input  logic              take,
  output logic [CYC_W-1:0]  cycles
);
  logic [7:0] full;

  assign full   = xfer_cost(op, cond_en, take);
  assign cycles = full[CYC_W-1:0];
endmodule

// File: rtl/branch_stack_unit.sv
module branch_stack_unit
  import bsu_pkg::*;
#(
  parameter logic [15:0] PC_INIT = 16'h0100,
  parameter logic [15:0] SP_INIT = 16'hFFFE,
  parameter int          CYC_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       op,
  input  logic             cond_en,
  input  logic [1:0]       cond_sel,
  input  logic [2:0]       vec_sel,
  input  logic [7:0]       flags,
  input  logic [15:0]      hl,
  output logic             mem_req,
  output logic             mem_we,
  output logic [15:0]      mem_addr,
  output logic [7:0]       mem_wdata,
  input  logic             mem_ack,
  input  logic [7:0]       mem_rdata,
  output logic             busy,
  output logic             done,
  output logic [CYC_W-1:0] done_cycles,
  output logic [15:0]      done_pc,
  output logic [15:0]      pc_out,
  output logic [15:0]      sp_out
);
  localparam logic [15:0] ONE = 16'd1;
  localparam logic [15:0] TWO = 16'd2;

  seq_state_e       state_q;
  xfer_op_e         op_q, op_in, cost_op;
  logic             cond_q, take_q, take_now, cost_cond, cost_take;
  logic [15:0]      pc_q, sp_q, tgt_q, push_q;
  logic             done_q;
  logic [15:0]      done_pc_q;
  logic [CYC_W-1:0] done_cyc_q, cost_now;

  // Named internal events used by the checker.
  logic             xfer_fire;
  logic             fin_evt;
  logic [15:0]      fin_pc;

  assign op_in = xfer_op_e'(op);

  bsu_cond_eval #(.FLAG_W(8), .ZERO_BIT(7), .CARRY_BIT(4)) i_cond (
    .flags(flags), .sel(cond_sel), .cond_en(cond_en), .take(take_now)
  );

  assign cost_op   = (state_q == ST_IDLE) ? op_in : op_q;
  assign cost_cond = (state_q == ST_IDLE) ? cond_en : cond_q;
  assign cost_take = (state_q == ST_IDLE) ? take_now : take_q;

  bsu_cost_calc #(.CYC_W(CYC_W)) i_cost (
    .op(cost_op), .cond_en(cost_cond), .take(cost_take), .cycles(cost_now)
  );

  assign xfer_fire = mem_req && mem_ack;

  // Memory port drive.
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = pc_q;
    mem_wdata = 8'h00;
    case (state_q)
      ST_FETCH_LO, ST_FETCH_HI: begin
        mem_req  = 1'b1;
        mem_addr = pc_q;
      end
      ST_PUSH_LO: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = sp_q;
        mem_wdata = push_q[7:0];
      end
      ST_PUSH_HI: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = sp_q + ONE;
        mem_wdata = push_q[15:8];
      end
      ST_POP_LO: begin
        mem_req  = 1'b1;
        mem_addr = sp_q;
      end
      ST_POP_HI: begin
        mem_req  = 1'b1;
        mem_addr = sp_q + ONE;
      end
      default: ;
    endcase
  end

  // Completion decision and resulting program counter.
  always_comb begin
    fin_evt = 1'b0;
    fin_pc  = pc_q;
    case (state_q)
      ST_IDLE: begin
        fin_evt = start && ((op_in == OP_JPHL) || ((op_in == OP_RET) && !take_now));
        fin_pc  = (op_in == OP_JPHL) ? hl : pc_q;
      end
      ST_FETCH_LO: begin
        fin_evt = xfer_fire && (op_q == OP_JR);
        fin_pc  = take_q ? rel_target(pc_q + ONE, mem_rdata) : pc_q + ONE;
      end
      ST_FETCH_HI: begin
        fin_evt = xfer_fire && !((op_q == OP_CALL) && take_q);
        fin_pc  = (take_q && (op_q == OP_JP)) ? {mem_rdata, tgt_q[7:0]} : pc_q + ONE;
      end
      ST_PUSH_HI: begin
        fin_evt = xfer_fire;
        fin_pc  = tgt_q;
      end
      ST_POP_HI: begin
        fin_evt = xfer_fire;
        fin_pc  = {mem_rdata, tgt_q[7:0]};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      op_q       <= OP_JR;
      cond_q     <= 1'b0;
      take_q     <= 1'b0;
      pc_q       <= PC_INIT;
      sp_q       <= SP_INIT;
      tgt_q      <= '0;
      push_q     <= '0;
      done_q     <= 1'b0;
      done_pc_q  <= '0;
      done_cyc_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            op_q   <= op_in;
            cond_q <= cond_en;
            take_q <= take_now;
            case (op_in)
              OP_JR, OP_JP, OP_CALL: state_q <= ST_FETCH_LO;
              OP_RET: if (take_now) state_q <= ST_POP_LO;
              OP_RST: begin
                sp_q    <= sp_q - TWO;
                push_q  <= pc_q;
                tgt_q   <= rst_target(vec_sel);
                state_q <= ST_PUSH_LO;
              end
              default: ;
            endcase
          end
        end
        ST_FETCH_LO: if (mem_ack) begin
          pc_q       <= pc_q + ONE;
          tgt_q[7:0] <= mem_rdata;
          state_q    <= ST_FETCH_HI;
        end
        ST_FETCH_HI: if (mem_ack) begin
          pc_q        <= pc_q + ONE;
          tgt_q[15:8] <= mem_rdata;
          if ((op_q == OP_CALL) && take_q) begin
            sp_q    <= sp_q - TWO;
            push_q  <= pc_q + ONE;
            state_q <= ST_PUSH_LO;
          end
        end
        ST_PUSH_LO: if (mem_ack) state_q <= ST_PUSH_HI;
        ST_POP_LO: if (mem_ack) begin
          tgt_q[7:0] <= mem_rdata;
          state_q    <= ST_POP_HI;
        end
        ST_POP_HI: if (mem_ack) sp_q <= sp_q + TWO;
        default: ;
      endcase
      if (fin_evt) begin
        state_q    <= ST_IDLE;
        pc_q       <= fin_pc;
        done_q     <= 1'b1;
        done_pc_q  <= fin_pc;
        done_cyc_q <= cost_now;
      end
    end
  end

  assign busy        = (state_q != ST_IDLE);
  assign done        = done_q;
  assign done_pc     = done_pc_q;
  assign done_cycles = done_cyc_q;
  assign pc_out      = pc_q;
  assign sp_out      = sp_q;
endmodule

// File: rtl/bsu_checker.sv
module bsu_checker #(
  parameter int CYC_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [CYC_W-1:0] done_cycles,
  input logic             mem_req,
  input logic             mem_ack,
  input logic             mem_we,
  input logic [15:0]      mem_addr,
  input logic [15:0]      sp_out,
  input logic             fin_evt
);
  a_r1_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  a_r12_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !mem_req));

  a_r11_done_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) || $past(start)));

  a_r12_fin_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    fin_evt |=> done);

  a_r4_write_window: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> ((mem_addr == sp_out) || (mem_addr == sp_out + 16'd1)));

  a_r5_sp_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sp_out) |-> ((sp_out == $past(sp_out) + 16'd2) ||
                          (sp_out == $past(sp_out) - 16'd2)));

  a_r7_cost_set: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_cycles == 4 || done_cycles == 8 || done_cycles == 12 ||
              done_cycles == 16 || done_cycles == 20 || done_cycles == 24));

  a_r10_quick_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_cycles == 4) |-> !$past(busy));
endmodule

bind branch_stack_unit bsu_checker #(.CYC_W(CYC_W)) i_bsu_checker (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .done_cycles(done_cycles), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_we(mem_we), .mem_addr(mem_addr), .sp_out(sp_out), .fin_evt(fin_evt)
);

// File: tb/test_branch_stack_unit.sv
module test_branch_stack_unit;
  localparam int          CLK_PERIOD = 10;
  localparam int          CYC_W      = 5;
  localparam logic [15:0] PC0        = 16'h0100;
  localparam logic [15:0] SP0        = 16'h0F00;
  localparam logic [2:0]  K_JR = 3'd0, K_JP = 3'd1, K_HL = 3'd2,
                          K_CALL = 3'd3, K_RET = 3'd4, K_RST = 3'd5;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, cond_en = 1'b0;
  logic [2:0] op = '0, vec_sel = '0;
  logic [1:0] cond_sel = '0;
  logic [7:0] flags = '0, mem_rdata = '0;
  logic [15:0] hl = '0;
  logic mem_ack = 1'b0;
  logic mem_req, mem_we, busy, done;
  logic [15:0] mem_addr, done_pc, pc_out, sp_out;
  logic [7:0] mem_wdata;
  logic [CYC_W-1:0] done_cycles;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_stack_unit #(.PC_INIT(PC0), .SP_INIT(SP0), .CYC_W(CYC_W)) i_branch_stack_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .cond_en(cond_en),
    .cond_sel(cond_sel), .vec_sel(vec_sel), .flags(flags), .hl(hl),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .done_cycles(done_cycles), .done_pc(done_pc), .pc_out(pc_out), .sp_out(sp_out)
  );

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Memory model with adjustable acknowledge latency.
  logic [7:0] mem [0:4095];
  int mem_wait = 0, wcnt = 0;
  always @(negedge clk) begin
    if (mem_req) begin
      if (wcnt >= mem_wait) begin
        mem_ack = 1'b1;
        mem_rdata = mem[mem_addr[11:0]];
        if (mem_we) mem[mem_addr[11:0]] = mem_wdata;
        wcnt = 0;
      end else begin
        mem_ack = 1'b0;
        wcnt++;
      end
    end else begin
      mem_ack = 1'b0;
      wcnt = 0;
    end
  end

  // Scoreboard.
  typedef struct { logic [15:0] pc; logic [15:0] cyc; string tag; } exp_t;
  exp_t sb[$];

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        checks++; fails++;
        $display("FAIL R11 unexpected done actual pc %h expected none", done_pc);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk({e.tag, " pc"}, done_pc, e.pc);
        chk({e.tag, " cycles"}, 16'(done_cycles), e.cyc);
      end
    end
  end

  // Bench model state.
  logic [15:0] model_pc = PC0, model_sp = SP0;
  logic [15:0] rstack[$];

  function automatic bit cond_ok(input logic [1:0] cc, input logic [7:0] fl);
    case (cc)
      2'd0: return fl[7] == 1'b0;
      2'd1: return fl[7] == 1'b1;
      2'd2: return fl[4] == 1'b0;
      default: return fl[4] == 1'b1;
    endcase
  endfunction

  task automatic issue(input logic [2:0] o, input logic ce, input logic [1:0] cc,
                       input logic [2:0] v, input logic [7:0] fl, input logic [15:0] h,
                       input logic [7:0] b0, input logic [7:0] b1, input string tag,
                       input bit intrude);
    exp_t e;
    bit taken, pushed;
    logic [15:0] ret_addr;
    int s;
    taken = !ce || cond_ok(cc, fl);
    pushed = 1'b0;
    ret_addr = '0;
    mem[12'(model_pc)] = b0;
    mem[12'(model_pc + 16'd1)] = b1;
    e.tag = tag;
    case (o)
      K_JR: begin
        s = (b0 >= 8'd128) ? int'(b0) - 256 : int'(b0);
        e.pc = taken ? 16'(int'(model_pc) + 1 + s) : model_pc + 16'd1;
        e.cyc = ce ? (taken ? 16'd12 : 16'd8) : 16'd12;
      end
      K_JP: begin
        e.pc = taken ? {b1, b0} : model_pc + 16'd2;
        e.cyc = ce ? (taken ? 16'd16 : 16'd12) : 16'd16;
      end
      K_CALL: begin
        e.cyc = ce ? (taken ? 16'd24 : 16'd12) : 16'd24;
        if (taken) begin
          ret_addr = model_pc + 16'd2;
          pushed = 1'b1;
          e.pc = {b1, b0};
        end else e.pc = model_pc + 16'd2;
      end
      K_RET: begin
        e.cyc = ce ? (taken ? 16'd20 : 16'd8) : 16'd16;
        if (taken) begin
          e.pc = rstack.pop_back();
          model_sp = model_sp + 16'd2;
        end else e.pc = model_pc;
      end
      K_RST: begin
        ret_addr = model_pc;
        pushed = 1'b1;
        e.pc = 16'(v) * 16'd8;
        e.cyc = 16'd16;
      end
      default: begin
        e.pc = h;
        e.cyc = 16'd4;
      end
    endcase
    if (pushed) begin
      rstack.push_back(ret_addr);
      model_sp = model_sp - 16'd2;
    end
    @(negedge clk);
    sb.push_back(e);
    op = o; cond_en = ce; cond_sel = cc; vec_sel = v; flags = fl; hl = h;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (intrude) begin
      op = K_HL; hl = 16'h0ABC; cond_en = 1'b0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    model_pc = e.pc;
    chk({tag, " pc_out"}, pc_out, model_pc);
    chk({tag, " sp_out (R5)"}, sp_out, model_sp);
    if (pushed) begin
      chk("R4 pushed low byte", 16'(mem[12'(model_sp)]), 16'(ret_addr[7:0]));
      chk("R4 pushed high byte", 16'(mem[12'(model_sp + 16'd1)]), 16'(ret_addr[15:8]));
    end
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 reset pc", pc_out, PC0);
    chk("R1 reset sp", sp_out, SP0);
    chk("R1 reset flags", {13'd0, busy, done, mem_req}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2/R7 absolute jump, little-endian operand
    issue(K_JP, 1'b0, 2'd0, 3'd0, 8'h00, 16'h0, 8'h34, 8'h02, "R2 R7 jp", 1'b0);
    // R3 forward and most negative offsets
    issue(K_JR, 1'b0, 2'd0, 3'd0, 8'h00, 16'h0, 8'h10, 8'h00, "R3 jr fwd", 1'b0);
    issue(K_JR, 1'b0, 2'd0, 3'd0, 8'h00, 16'h0, 8'h80, 8'h00, "R3 jr -128", 1'b0);
    mem_wait = 2;
    // R6 R8 conditional relative jumps
    issue(K_JR, 1'b1, 2'd1, 3'd0, 8'h80, 16'h0, 8'h05, 8'h00, "R6 R8 jr z taken", 1'b0);
    issue(K_JR, 1'b1, 2'd1, 3'd0, 8'h00, 16'h0, 8'h05, 8'h00, "R6 R8 jr z skip", 1'b0);
    // R6 R8 conditional absolute jumps on carry
    issue(K_JP, 1'b1, 2'd3, 3'd0, 8'h10, 16'h0, 8'h00, 8'h03, "R6 R8 jp c taken", 1'b0);
    issue(K_JP, 1'b1, 2'd2, 3'd0, 8'h10, 16'h0, 8'h77, 8'h07, "R2 R8 jp nc skip", 1'b0);
    // R4 R11 call with an ignored start while busy
    issue(K_CALL, 1'b0, 2'd0, 3'd0, 8'h00, 16'h0, 8'h00, 8'h08, "R4 R11 call", 1'b1);
    mem_wait = 0;
    issue(K_CALL, 1'b1, 2'd0, 3'd0, 8'h00, 16'h0, 8'h00, 8'h09, "R6 R8 call nz taken", 1'b0);
    issue(K_CALL, 1'b1, 2'd0, 3'd0, 8'h80, 16'h0, 8'h00, 8'h0A, "R8 call nz skip", 1'b0);
    // R5 R8 conditional returns
    issue(K_RET, 1'b1, 2'd3, 3'd0, 8'h00, 16'h0, 8'h00, 8'h00, "R8 ret c skip", 1'b0);
    issue(K_RET, 1'b1, 2'd2, 3'd0, 8'h00, 16'h0, 8'h00, 8'h00, "R5 R8 ret nc taken", 1'b0);
    mem_wait = 1;
    issue(K_RET, 1'b0, 2'd0, 3'd0, 8'h00, 16'h0, 8'h00, 8'h00, "R5 R7 ret", 1'b0);
    // R9 restart vectors, condition enable ignored
    issue(K_RST, 1'b1, 2'd1, 3'd7, 8'h00, 16'h0, 8'h00, 8'h00, "R9 rst 0x38", 1'b0);
    issue(K_RET, 1'b0, 2'd0, 3'd0, 8'h00, 16'h0, 8'h00, 8'h00, "R5 ret from rst", 1'b0);
    issue(K_RST, 1'b0, 2'd0, 3'd0, 8'h00, 16'h0, 8'h00, 8'h00, "R9 rst 0x00", 1'b0);
    issue(K_RET, 1'b0, 2'd0, 3'd0, 8'h00, 16'h0, 8'h00, 8'h00, "R5 ret from rst0", 1'b0);
    // R10 jump through hl with an unmet condition
    issue(K_HL, 1'b1, 2'd1, 3'd0, 8'h00, 16'h0456, 8'h00, 8'h00, "R10 jp hl", 1'b0);
    repeat (3) @(negedge clk);
    chk("R11 no leftover results", 16'(sb.size()), 16'd0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule